// File: doc/BRIEF.md
# Comparator Offset Trim Sequencer

This block runs one calibration pass after power-on for a loop-unrolled successive-approximation converter. A start pulse launches the pass. During the pass the block shorts the converter inputs and ties the two capacitor arrays together, so each comparator sees a zero differential signal at the common mode it has in normal use. It also forces every programmable delay line to its longest setting and asks the clock source for a slower conversion clock. The converter keeps running its ordinary conversion sequence, and each finished conversion is reported on `conv_done` together with the decision of every comparator.

The sequencer trims five comparators one after another. Indices 0 to 3 are the four most-significant-bit comparators, and index 4 is the reference comparator. For each comparator it first finds the sign of the trim code. It then resolves the four magnitude bits from the top bit down. Every trial is settled by a majority vote over a fixed number of conversions. Once the last bit of the last comparator is resolved, the controls are released, the normal delay codes return, and `done` stays high until the next reset. The trim codes are register outputs that feed the analog trim devices.

Top module: `ofs_trim_seq`

## Requirements
- R1: After a synchronous active-low reset, the following are all low: `in_short`, `arr_short`, `slow_clk_req` and `done`. Every trim code is zero. No calibration begins until `start` is seen.
- R2: `start` sampled high in the idle state raises `in_short`, `arr_short` and `slow_clk_req` on the next cycle. `start` has no effect while calibration is running or after `done`.
- R3: While calibration runs, every 3-bit field of `dly_code` reads 7. At all other times `dly_code` equals `dly_cfg`.
- R4: Comparators are trimmed in index order 0, 1, 2, 3, 4. Only bit c of `cmp_dec` is used while comparator c is trimmed. Trim code c sits at `trim_code[5c+4:5c]`, and codes of other comparators do not change.
- R5: A trim code is sign-magnitude: bit 4 is the sign and bits 3:0 are the magnitude. The first trial runs with the code at zero and writes the vote result into the sign bit. Codes change only while calibration runs.
- R6: Magnitude bits are tried from bit 3 down to bit 0. Each bit is set before its trial. The bit is kept if the vote equals the sign bit and cleared otherwise. The next lower bit is set in the same cycle.
- R7: A vote takes 16 accepted conversions. It yields 1 when at least 9 decisions are 1. Exactly 8 ones yields 0.
- R8: After calibration starts and after each trial is resolved, `conv_done` is ignored for 5 cycles before votes are counted again. With a conversion reported every cycle, `done` rises 525 cycles after the cycle in which `start` was taken.
- R9: After the last trial, `in_short`, `arr_short` and `slow_clk_req` fall together, `done` rises, and both `done` and the trim codes hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the calibration pass (taken only when idle) |
| conv_done | input | 1 | One conversion finished this cycle |
| cmp_dec | input | 5 | Decision of each comparator for that conversion (1 = positive) |
| dly_cfg | input | 24 | Normal delay-line codes, 3 bits per line |
| in_short | output | 1 | Short the converter inputs together |
| arr_short | output | 1 | Short the two capacitor arrays together |
| slow_clk_req | output | 1 | Ask for the reduced conversion clock |
| dly_code | output | 24 | Delay-line codes applied to the converter |
| trim_code | output | 25 | Five sign-magnitude trim codes, 5 bits each |
| done | output | 1 | Calibration complete (sticky until reset) |

## Verification
The bench checks the vote threshold in both directions. Nine ones must set the sign and exactly eight must not, so a design whose comparison is off by one would get the sign wrong on a balanced comparator. It also sends decisions during the post-update quiet window that would change the vote if they were counted. A design that counted them would resolve the trial early and with the wrong value. Full passes use a model of comparator offset that includes minority noise and exact-zero residuals. They would catch a wrong decision bit being selected, a bit kept or cleared with the wrong polarity, or a trial order other than sign first and then bits 3 down to 0. The completion latency, the release of the controls, and the insensitivity to `start` pulses during and after the pass are also checked.

// File: rtl/ofs_trim_pkg.sv
// Shared types for the comparator offset trim sequencer.
package ofs_trim_pkg;

    // Calibration controller states.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_COLLECT = 2'd2,
        ST_DONE    = 2'd3
    } cal_state_t;

endpackage

// File: rtl/ofs_settle_timer.sv
// Quiet-window timer: after load it counts SETTLE_CYC down to zero.
// expired is high once the count is zero. Assumes load is a single-cycle pulse.
module ofs_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(SETTLE_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ofs_vote_tally.sv
// Majority tally over VOTES accepted decisions. On the last accepted vote it
// pulses vote_done, with vote_maj high when more than VOTES/2 decisions are 1.
// Assumes clear and accept are never high in the same cycle.
module ofs_vote_tally #(
    parameter int VOTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic accept,
    input  logic dec,
    output logic vote_done,
    output logic vote_maj
);
    localparam int CW = $clog2(VOTES + 1);

    logic [CW-1:0] n_seen;
    logic [CW-1:0] n_ones;
    logic [CW-1:0] ones_incl;

    // Ones count including the decision being accepted this cycle.
    always_comb begin
        ones_incl = n_ones + CW'(dec);
    end

    assign vote_done = accept && (n_seen == CW'(VOTES - 1));
    assign vote_maj  = (ones_incl > CW'(VOTES / 2));

    // Accumulate decisions; restart on clear or when a vote closes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || vote_done) begin
            n_seen <= '0;
            n_ones <= '0;
        end else if (accept) begin
            n_seen <= n_seen + 1'b1;
            n_ones <= ones_incl;
        end
    end
endmodule

// File: rtl/ofs_trim_ctrl.sv
// Sequencing controller. It walks the comparators in index order and, for each,
// one sign trial followed by MAG_W magnitude trials. Each trial is a quiet
// settle window followed by vote collection. Done is sticky until reset.
module ofs_trim_ctrl
    import ofs_trim_pkg::*;
#(
    parameter int NUM_CMP = 5,
    parameter int MAG_W   = 4,
    parameter int SEL_W   = 3,
    parameter int TR_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             conv_done,
    input  logic             timer_expired,
    input  logic             vote_done,
    output logic             cal_on,
    output logic             done,
    output logic             accept,
    output logic             load,
    output logic [SEL_W-1:0] sel,
    output logic [TR_W-1:0]  trial
);
    cal_state_t       state, state_nx;
    logic [SEL_W-1:0] sel_nx;
    logic [TR_W-1:0]  trial_nx;
    logic             last_trial;
    logic             last_cmp;

    assign last_trial = (trial == TR_W'(MAG_W));
    assign last_cmp   = (sel == SEL_W'(NUM_CMP - 1));

    // Next-state, index and trial selection.
    always_comb begin
        state_nx = state;
        sel_nx   = sel;
        trial_nx = trial;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_SETTLE;
                    sel_nx   = '0;
                    trial_nx = '0;
                    load     = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (timer_expired) begin
                    state_nx = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (vote_done) begin
                    if (last_trial && last_cmp) begin
                        state_nx = ST_DONE;
                    end else begin
                        state_nx = ST_SETTLE;
                        load     = 1'b1;
                        if (last_trial) begin
                            sel_nx   = sel + 1'b1;
                            trial_nx = '0;
                        end else begin
                            trial_nx = trial + 1'b1;
                        end
                    end
                end
            end
            ST_DONE: begin
                state_nx = ST_DONE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State, comparator index and trial registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
            trial <= '0;
        end else begin
            state <= state_nx;
            sel   <= sel_nx;
            trial <= trial_nx;
        end
    end

    assign cal_on = (state == ST_SETTLE) || (state == ST_COLLECT);
    assign done   = (state == ST_DONE);
    assign accept = (state == ST_COLLECT) && conv_done;
endmodule

// File: rtl/ofs_trim_bank.sv
// One sign-magnitude trim register per comparator. On resolve, the selected
// register takes the vote for the current trial and arms the next lower
// magnitude bit. Assumes trial 0 is the sign trial and trials 1..MAG_W cover
// magnitude bits MAG_W-1 down to 0.
module ofs_trim_bank #(
    parameter int NUM_CMP = 5,
    parameter int MAG_W   = 4,
    parameter int SEL_W   = 3,
    parameter int TR_W    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           resolve,
    input  logic [SEL_W-1:0]               sel,
    input  logic [TR_W-1:0]                trial,
    input  logic                           maj,
    output logic [NUM_CMP*(MAG_W+1)-1:0]   trim_code
);
    localparam int TW = MAG_W + 1;

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        logic [TW-1:0] code, code_nx;

        // Trial update for this comparator's code.
        always_comb begin
            code_nx = code;
            if (resolve && (sel == SEL_W'(c))) begin
                if (trial == '0) begin
                    code_nx[MAG_W]     = maj;
                    code_nx[MAG_W - 1] = 1'b1;
                end else begin
                    for (int k = 0; k < MAG_W; k++) begin
                        if ((k == MAG_W - int'(trial)) && (maj != code[MAG_W])) begin
                            code_nx[k] = 1'b0;
                        end
                        if (k == MAG_W - int'(trial) - 1) begin
                            code_nx[k] = 1'b1;
                        end
                    end
                end
            end
        end

        // Code register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code <= '0;
            end else begin
                code <= code_nx;
            end
        end

        assign trim_code[c*TW +: TW] = code;
    end
endmodule

// File: rtl/ofs_trim_seq.sv
// Power-on comparator offset trim sequencer (top). It holds the converter in
// its zero-input calibration setup, with inputs shorted, arrays shorted, delays
// at maximum and the slow clock requested. It trims each comparator by a
// vote-driven successive search, then releases the setup. Assumes cmp_dec is
// valid whenever conv_done is high.
module ofs_trim_seq #(
    parameter int NUM_CMP    = 5,
    parameter int MAG_W      = 4,
    parameter int VOTES      = 16,
    parameter int SETTLE_CYC = 4,
    parameter int NUM_DLY    = 8,
    parameter int DLY_W      = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           conv_done,
    input  logic [NUM_CMP-1:0]             cmp_dec,
    input  logic [NUM_DLY*DLY_W-1:0]       dly_cfg,
    output logic                           in_short,
    output logic                           arr_short,
    output logic                           slow_clk_req,
    output logic [NUM_DLY*DLY_W-1:0]       dly_code,
    output logic [NUM_CMP*(MAG_W+1)-1:0]   trim_code,
    output logic                           done
);
    localparam int SEL_W = (NUM_CMP < 2) ? 1 : $clog2(NUM_CMP);
    localparam int TR_W  = $clog2(MAG_W + 1);

    logic             cal_on;
    logic             accept;
    logic             load;
    logic             timer_expired;
    logic             vote_done;
    logic             vote_maj;
    logic             cur_dec;
    logic [SEL_W-1:0] sel;
    logic [TR_W-1:0]  trial;

    ofs_trim_ctrl #(
        .NUM_CMP(NUM_CMP), .MAG_W(MAG_W), .SEL_W(SEL_W), .TR_W(TR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .conv_done(conv_done),
        .timer_expired(timer_expired), .vote_done(vote_done),
        .cal_on(cal_on), .done(done), .accept(accept), .load(load),
        .sel(sel), .trial(trial)
    );

    ofs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .expired(timer_expired)
    );

    // Pick the decision of the comparator under trim.
    always_comb begin
        cur_dec = 1'b0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (sel == SEL_W'(i)) begin
                cur_dec = cmp_dec[i];
            end
        end
    end

    ofs_vote_tally #(.VOTES(VOTES)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear(load), .accept(accept),
        .dec(cur_dec), .vote_done(vote_done), .vote_maj(vote_maj)
    );

    ofs_trim_bank #(
        .NUM_CMP(NUM_CMP), .MAG_W(MAG_W), .SEL_W(SEL_W), .TR_W(TR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .resolve(vote_done), .sel(sel),
        .trial(trial), .maj(vote_maj), .trim_code(trim_code)
    );

    // Delay-line override: longest setting while calibrating.
    for (genvar j = 0; j < NUM_DLY; j++) begin : g_dly
        assign dly_code[j*DLY_W +: DLY_W] = cal_on ? {DLY_W{1'b1}} : dly_cfg[j*DLY_W +: DLY_W];
    end

    assign in_short     = cal_on;
    assign arr_short    = cal_on;
    assign slow_clk_req = cal_on;
endmodule

// File: rtl/ofs_trim_seq_chk.sv
// Property checker for ofs_trim_seq, attached by bind. It observes ports only.
module ofs_trim_seq_chk #(
    parameter int NUM_CMP = 5,
    parameter int MAG_W   = 4,
    parameter int NUM_DLY = 8,
    parameter int DLY_W   = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic [NUM_DLY*DLY_W-1:0]     dly_cfg,
    input logic                         in_short,
    input logic                         arr_short,
    input logic                         slow_clk_req,
    input logic [NUM_DLY*DLY_W-1:0]     dly_code,
    input logic [NUM_CMP*(MAG_W+1)-1:0] trim_code,
    input logic                         done
);
    AST_START_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_short) |-> $past(start)); // R2

    AST_DLY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        in_short |-> (dly_code == {NUM_DLY*DLY_W{1'b1}})); // R3

    AST_DLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_short |-> (dly_code == dly_cfg)); // R3

    AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_short |=> $stable(trim_code)); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R9

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_short && !arr_short && !slow_clk_req)); // R9

    AST_CAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_short) |-> done); // R9
endmodule

bind ofs_trim_seq ofs_trim_seq_chk #(
    .NUM_CMP(NUM_CMP), .MAG_W(MAG_W), .NUM_DLY(NUM_DLY), .DLY_W(DLY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dly_cfg(dly_cfg),
    .in_short(in_short), .arr_short(arr_short), .slow_clk_req(slow_clk_req),
    .dly_code(dly_code), .trim_code(trim_code), .done(done)
);

// File: tb/tb_ofs_trim_seq.sv
`timescale 1ns/1ps
// Directed bench for ofs_trim_seq: one task per scenario, each checking itself.
module tb_ofs_trim_seq;
    localparam int NC = 5;
    localparam int TW = 5;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          conv_done = 1'b0;
    logic [NC-1:0] cmp_dec = '0;
    logic [DW-1:0] dly_cfg = 24'h5A3C91;
    logic          in_short, arr_short, slow_clk_req, done;
    logic [DW-1:0] dly_code;
    logic [NC*TW-1:0] trim_code;

    int n_chk = 0;
    int n_bad = 0;
    int offs[NC];
    int mcyc = 0;

    ofs_trim_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .conv_done(conv_done),
        .cmp_dec(cmp_dec), .dly_cfg(dly_cfg), .in_short(in_short),
        .arr_short(arr_short), .slow_clk_req(slow_clk_req),
        .dly_code(dly_code), .trim_code(trim_code), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Comparator model: decision follows the sign of offset minus correction.
    // A zero residual alternates; optional noise flips 3 of every 16 decisions.
    function automatic logic model_dec(int i, logic [TW-1:0] code, int c, bit nz);
        int res;
        logic d;
        res = offs[i] - (code[4] ? int'(code[3:0]) : -int'(code[3:0]));
        if (res == 0) return logic'(c % 2);
        d = (res > 0);
        if (nz && (c % 16) < 3) d = ~d;
        return d;
    endfunction

    function automatic int exp_code(int o);
        if (o > 0) return 16 + ((o - 1 > 15) ? 15 : o - 1);
        return (-o > 15) ? 15 : -o;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; conv_done = 1'b0; cmp_dec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Call at the negedge right after the edge that entered the settle window.
    // Five ignored all-ones conversions, then 16 votes with `ones` ones first.
    task automatic feed_trial(int ones);
        conv_done = 1'b1;
        cmp_dec = '1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            cmp_dec = (k < ones) ? '1 : '0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 in_short", in_short, 0);
        chk("R1 arr_short", arr_short, 0);
        chk("R1 slow_clk_req", slow_clk_req, 0);
        chk("R1 done", done, 0);
        chk("R1 trim zero", (trim_code == '0), 1);
        chk("R3 delay pass", (dly_code == dly_cfg), 1);
        conv_done = 1'b1; cmp_dec = '1;
        repeat (10) @(negedge clk);
        conv_done = 1'b0;
        chk("R1 no start stays idle", in_short, 0);
        chk("R1 no start trim zero", (trim_code == '0), 1);
    endtask

    task automatic t_votes(int ones1, int exp1, int ones2, int exp2);
        do_reset();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 controls raised", {in_short, arr_short, slow_clk_req}, 7);
        chk("R3 delays forced", (dly_code == {DW{1'b1}}), 1);
        feed_trial(ones1);
        chk("R7 R8 sign trial code", int'(trim_code[4:0]), exp1);
        chk("R4 other codes untouched", int'(trim_code[NC*TW-1:TW]), 0);
        feed_trial(ones2);
        conv_done = 1'b0;
        chk("R6 first magnitude trial", int'(trim_code[4:0]), exp2);
        chk("R4 other codes still untouched", int'(trim_code[NC*TW-1:TW]), 0);
    endtask

    task automatic t_full_run(int o0, int o1, int o2, int o3, int o4, bit nz, bit mid_start);
        int cnt;
        logic [NC*TW-1:0] held;
        offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3; offs[4] = o4;
        do_reset();
        start = 1'b1;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            start = mid_start && (cnt == 200);
            cnt++;
            if (cnt == 50) begin
                chk("R2 controls during pass", {in_short, arr_short, slow_clk_req}, 7);
                chk("R3 delays forced during pass", (dly_code == {DW{1'b1}}), 1);
            end
            if (cnt > 4000) break;
            conv_done = 1'b1;
            for (int i = 0; i < NC; i++) begin
                cmp_dec[i] = model_dec(i, trim_code[i*TW +: TW], mcyc, nz);
            end
            mcyc++;
        end
        conv_done = 1'b0;
        start = 1'b0;
        chk("R8 completion latency", cnt, 525);
        chk("R9 done high", done, 1);
        chk("R9 controls released", {in_short, arr_short, slow_clk_req}, 0);
        chk("R3 delays restored", (dly_code == dly_cfg), 1);
        for (int i = 0; i < NC; i++) begin
            chk("R6 final trim code", int'(trim_code[i*TW +: TW]), exp_code(offs[i]));
        end
        held = trim_code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        conv_done = 1'b1; cmp_dec = '1;
        repeat (30) @(negedge clk);
        conv_done = 1'b0;
        chk("R2 start ignored after done", in_short, 0);
        chk("R9 done sticky", done, 1);
        chk("R9 trim held", (trim_code == held), 1);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_votes(9, 5'b11000, 0, 5'b10100);
        t_votes(8, 5'b01000, 3, 5'b01100);
        t_full_run(5, -3, 0, 12, -20, 1'b0, 1'b0);
        t_full_run(1, -1, 17, -15, 7, 1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule